// File: doc/BRIEF.md
# Configurable Modular Step Counter

This block is a synchronous binary counter whose register advances by a fixed step on each enabled clock edge. The direction is fixed at elaboration as upward or downward, or taken from an input pin at run time. Without a programmed limit the count rolls over at the natural width boundary. With a limit enabled it returns to zero on the edge after the register equals the limit value. That test is an exact equality match, so a count that jumps over the limit keeps running.

Several synchronous controls sit around the count. A clear forces zero, a set forces all ones, an initialise forces a parameter value, and a parallel load copies an input word whose active level is selectable. An optional clock enable and an optional threshold flag complete the set. Two parameters settle conflicts. One picks the winner when clear and set are both asserted. The other decides whether clear, set and initialise act on their own or only while the clock enable is high. A power-on reset input puts the register to a power-up parameter value. Typical uses are address generators, modulo sequencers and event dividers, where each instance enables only the controls it needs.

Top module: `stepcnt_top`

## Requirements
- R1: While `rst` is high, the next rising edge loads `count` with the parameter POWERUP_VAL.
- R2: On a counting edge going upward, `count` becomes the old value plus STEP modulo 2^WIDTH. For example, 8'hFF plus 3 gives 8'h02.
- R3: Mode encoding: 0 counts up, 1 counts down, 2 takes the direction from `countUp` (high means up, low means down). Counting down subtracts STEP modulo 2^WIDTH.
- R4: With RESTRICT set and counting upward, an enabled edge that sees `count` equal to FINAL_VAL loads zero instead of stepping.
- R5: With RESTRICT set and counting downward, the same equality gives zero on the next enabled edge. Counting then continues downward and wraps through the top of the range (width 4, step 3, limit 10: 0, 13, 10, 0, 13).
- R6: The limit test is equality only. A count loaded off the step grid passes FINAL_VAL and keeps stepping without wrapping.
- R7: `syncClr` gives zero and `syncSet` gives all ones. When both are asserted, SET_WINS=0 (the default) makes the clear win and SET_WINS=1 makes the set win.
- R8: `syncInit` loads the parameter INIT_VAL.
- R9: With CE_GATES_SYNC=0, clear, set and initialise act even while `clkEn` is low. With CE_GATES_SYNC=1 they are ignored while `clkEn` is low.
- R10: The load is active when `loadEn` equals LOAD_ACTIVE_HIGH, and it then places `loadVal` in `count`. It acts only while `clkEn` is high. It loses to clear, set and initialise, and it beats counting.
- R11: With `clkEn` low and no synchronous control acting, `count` holds its value.
- R12: `threshHit` is high, combinationally from the register, exactly while `count` equals THRESH_VAL (HAS_THRESH=1).

Each optional input has its own enable parameter (HAS_CE, HAS_CLR, HAS_SET, HAS_INIT, HAS_LOAD). An input whose enable is zero is ignored. Without HAS_CE the block behaves as if the enable were always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Power-on reset, loads POWERUP_VAL |
| clkEn | input | 1 | Clock enable, active high |
| syncClr | input | 1 | Synchronous clear to zero |
| syncSet | input | 1 | Synchronous set to all ones |
| syncInit | input | 1 | Synchronous initialise to INIT_VAL |
| countUp | input | 1 | Direction in mode 2: high up, low down |
| loadEn | input | 1 | Parallel load request, polarity per LOAD_ACTIVE_HIGH |
| loadVal | input | WIDTH | Parallel load word |
| count | output | WIDTH | Counter register |
| threshHit | output | 1 | High while count equals THRESH_VAL |

## Verification
The collisions that matter are cases where a synchronous control and a load, a count step or a low clock enable meet in the same cycle. The bench provokes them by asserting clear together with set, and clear or initialise together with an active load. It also drives clear or set while the enable is low, in one instance that lets them override the enable and in one that gates them with it. Each collision is judged by the register value one edge later: zero, all ones, INIT_VAL or the unchanged count, whichever the priority parameters name, and never the loaded word or the stepped value.

// File: rtl/stepcnt_pkg.sv
package stepcnt_pkg;

  typedef enum logic [1:0] {
    CNT_UP     = 2'd0,
    CNT_DOWN   = 2'd1,
    CNT_UPDOWN = 2'd2
  } countMode_e;

  // One action per edge; control guarantees at most one of the do* bits.
  typedef struct packed {
    logic doClr;
    logic doSet;
    logic doInit;
    logic doLoad;
    logic doCount;
    logic dirUp;
  } cntStrobe_t;

endpackage

// File: rtl/stepcnt_ctrl.sv
module stepcnt_ctrl
  import stepcnt_pkg::*;
#(
  parameter countMode_e MODE             = CNT_UP,
  parameter bit         HAS_CE           = 1'b1,
  parameter bit         HAS_CLR          = 1'b1,
  parameter bit         HAS_SET          = 1'b0,
  parameter bit         HAS_INIT         = 1'b0,
  parameter bit         HAS_LOAD         = 1'b0,
  parameter bit         LOAD_ACTIVE_HIGH = 1'b1,
  parameter bit         SET_WINS         = 1'b0,
  parameter bit         CE_GATES_SYNC    = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clkEn,
  input  logic       syncClr,
  input  logic       syncSet,
  input  logic       syncInit,
  input  logic       countUp,
  input  logic       loadEn,
  output cntStrobe_t strobe
);

  logic ceEff;
  logic syncGate;
  logic clrReq, setReq, initReq, loadReq;
  logic clrWin, setWin, initWin, anySync;
  logic dirUp;

  assign ceEff    = HAS_CE ? clkEn : 1'b1;
  assign syncGate = CE_GATES_SYNC ? ceEff : 1'b1;

  assign clrReq  = HAS_CLR  && syncClr  && syncGate;
  assign setReq  = HAS_SET  && syncSet  && syncGate;
  assign initReq = HAS_INIT && syncInit && syncGate;
  assign loadReq = HAS_LOAD && (loadEn == LOAD_ACTIVE_HIGH) && ceEff;

  generate
    if (SET_WINS) begin : g_setFirst
      assign setWin = setReq;
      assign clrWin = clrReq && !setReq;
    end else begin : g_clrFirst
      assign clrWin = clrReq;
      assign setWin = setReq && !clrReq;
    end
  endgenerate

  assign initWin = initReq && !clrReq && !setReq;
  assign anySync = clrReq || setReq || initReq;

  generate
    if (MODE == CNT_UP) begin : g_dirUp
      assign dirUp = 1'b1;
    end else if (MODE == CNT_DOWN) begin : g_dirDown
      assign dirUp = 1'b0;
    end else begin : g_dirPin
      assign dirUp = countUp;
    end
  endgenerate

  always_comb begin
    strobe         = '0;
    strobe.doClr   = clrWin;
    strobe.doSet   = setWin;
    strobe.doInit  = initWin;
    strobe.doLoad  = loadReq && !anySync;
    strobe.doCount = ceEff && !anySync && !loadReq;
    strobe.dirUp   = dirUp;
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.doClr, strobe.doSet, strobe.doInit, strobe.doLoad, strobe.doCount})); // R10
  AST_CE_LOW_STALLS: assert property (@(posedge clk) disable iff (rst)
    (HAS_CE && !clkEn) |-> (!strobe.doCount && !strobe.doLoad)); // R11
  AST_CLR_SET_ORDER: assert property (@(posedge clk) disable iff (rst)
    (HAS_CLR && HAS_SET && syncClr && syncSet && (!CE_GATES_SYNC || !HAS_CE || clkEn))
      |-> (SET_WINS ? (strobe.doSet && !strobe.doClr) : (strobe.doClr && !strobe.doSet))); // R7
  AST_SYNC_BEATS_LOAD: assert property (@(posedge clk) disable iff (rst)
    (HAS_CLR && syncClr && !CE_GATES_SYNC) |-> !strobe.doLoad); // R10

endmodule

// File: rtl/stepcnt_dp.sv
module stepcnt_dp
  import stepcnt_pkg::*;
#(
  parameter int unsigned      WIDTH       = 16,
  parameter logic [WIDTH-1:0] STEP        = 1,
  parameter bit               RESTRICT    = 1'b0,
  parameter logic [WIDTH-1:0] FINAL_VAL   = 1,
  parameter logic [WIDTH-1:0] INIT_VAL    = 0,
  parameter logic [WIDTH-1:0] POWERUP_VAL = 0,
  parameter bit               HAS_THRESH  = 1'b0,
  parameter logic [WIDTH-1:0] THRESH_VAL  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  cntStrobe_t       strobe,
  input  logic [WIDTH-1:0] loadVal,
  output logic [WIDTH-1:0] count,
  output logic             threshHit
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] countQ;
  logic [WIDTH-1:0] stepUp, stepDown, stepped;
  logic             atFinal;

  assign stepUp   = countQ + STEP;
  assign stepDown = countQ - STEP;

  generate
    if (RESTRICT) begin : g_limit
      assign atFinal = (countQ == FINAL_VAL);
    end else begin : g_natural
      assign atFinal = 1'b0;
    end
  endgenerate

  always_comb begin
    stepped = strobe.dirUp ? stepUp : stepDown;
    if (atFinal) stepped = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)                 countQ <= POWERUP_VAL;
    else if (strobe.doClr)   countQ <= '0;
    else if (strobe.doSet)   countQ <= ALL_ONES;
    else if (strobe.doInit)  countQ <= INIT_VAL;
    else if (strobe.doLoad)  countQ <= loadVal;
    else if (strobe.doCount) countQ <= stepped;
  end

  generate
    if (HAS_THRESH) begin : g_thresh
      assign threshHit = (countQ == THRESH_VAL);
    end else begin : g_noThresh
      assign threshHit = 1'b0;
    end
  endgenerate

  assign count = countQ;

  AST_CLR_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    strobe.doClr |=> (countQ == '0)); // R7
  AST_SET_TO_ONES: assert property (@(posedge clk) disable iff (rst)
    strobe.doSet |=> (countQ == ALL_ONES)); // R7
  AST_INIT_VALUE: assert property (@(posedge clk) disable iff (rst)
    strobe.doInit |=> (countQ == INIT_VAL)); // R8
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    strobe.doLoad |=> (countQ == $past(loadVal))); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(strobe.doClr || strobe.doSet || strobe.doInit || strobe.doLoad || strobe.doCount)
      |=> $stable(countQ)); // R11
  AST_FINAL_WRAP: assert property (@(posedge clk) disable iff (rst)
    (RESTRICT && strobe.doCount && countQ == FINAL_VAL) |=> (countQ == '0)); // R4
  AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
    (strobe.doCount && strobe.dirUp && !(RESTRICT && countQ == FINAL_VAL))
      |=> (countQ == $past(countQ) + STEP)); // R2
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (strobe.doCount && !strobe.dirUp && !(RESTRICT && countQ == FINAL_VAL))
      |=> (countQ == $past(countQ) - STEP)); // R3

endmodule

// File: rtl/stepcnt_top.sv
module stepcnt_top
  import stepcnt_pkg::*;
#(
  parameter int unsigned      WIDTH            = 16,
  parameter countMode_e       MODE             = CNT_UP,
  parameter logic [WIDTH-1:0] STEP             = 1,
  parameter bit               RESTRICT         = 1'b0,
  parameter logic [WIDTH-1:0] FINAL_VAL        = 1,
  parameter bit               HAS_CE           = 1'b1,
  parameter bit               HAS_CLR          = 1'b1,
  parameter bit               HAS_SET          = 1'b0,
  parameter bit               HAS_INIT         = 1'b0,
  parameter logic [WIDTH-1:0] INIT_VAL         = 0,
  parameter bit               HAS_LOAD         = 1'b0,
  parameter bit               LOAD_ACTIVE_HIGH = 1'b1,
  parameter bit               SET_WINS         = 1'b0,
  parameter bit               CE_GATES_SYNC    = 1'b0,
  parameter logic [WIDTH-1:0] POWERUP_VAL      = 0,
  parameter bit               HAS_THRESH       = 1'b0,
  parameter logic [WIDTH-1:0] THRESH_VAL       = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clkEn,
  input  logic             syncClr,
  input  logic             syncSet,
  input  logic             syncInit,
  input  logic             countUp,
  input  logic             loadEn,
  input  logic [WIDTH-1:0] loadVal,
  output logic [WIDTH-1:0] count,
  output logic             threshHit
);

  cntStrobe_t strobe;

  stepcnt_ctrl #(
    .MODE(MODE), .HAS_CE(HAS_CE), .HAS_CLR(HAS_CLR), .HAS_SET(HAS_SET),
    .HAS_INIT(HAS_INIT), .HAS_LOAD(HAS_LOAD), .LOAD_ACTIVE_HIGH(LOAD_ACTIVE_HIGH),
    .SET_WINS(SET_WINS), .CE_GATES_SYNC(CE_GATES_SYNC)
  ) ctrl_i (
    .clk(clk), .rst(rst), .clkEn(clkEn), .syncClr(syncClr), .syncSet(syncSet),
    .syncInit(syncInit), .countUp(countUp), .loadEn(loadEn), .strobe(strobe)
  );

  stepcnt_dp #(
    .WIDTH(WIDTH), .STEP(STEP), .RESTRICT(RESTRICT), .FINAL_VAL(FINAL_VAL),
    .INIT_VAL(INIT_VAL), .POWERUP_VAL(POWERUP_VAL), .HAS_THRESH(HAS_THRESH),
    .THRESH_VAL(THRESH_VAL)
  ) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .loadVal(loadVal),
    .count(count), .threshHit(threshHit)
  );

endmodule

// File: tb/stepcnt_tb.sv
`timescale 1ns/1ps
module stepcnt_top_tb_top;
  import stepcnt_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;

  // Instance A: 8 bit, pin direction, step 3, active-low load, threshold 9
  logic       ceA = 0, clrA = 0, setA = 0, upA = 1, ldNA = 1;
  logic [7:0] ldValA = 0, cntA;
  logic       thA;

  // Instance B: 8 bit, up, step 2, limit 8, init 4, enable gates sync
  logic       ceB = 0, initB = 0, ldB = 0;
  logic [7:0] ldValB = 0, cntB;
  logic       thB;

  // Instance C: 4 bit, down, step 3, limit 10, clear
  logic       ceC = 0, clrC = 0;
  logic [3:0] cntC;
  logic       thC;

  stepcnt_top #(
    .WIDTH(8), .MODE(CNT_UPDOWN), .STEP(8'd3), .HAS_CE(1'b1), .HAS_CLR(1'b1),
    .HAS_SET(1'b1), .HAS_LOAD(1'b1), .LOAD_ACTIVE_HIGH(1'b0), .SET_WINS(1'b0),
    .CE_GATES_SYNC(1'b0), .POWERUP_VAL(8'h05), .HAS_THRESH(1'b1), .THRESH_VAL(8'h09)
  ) dut_i (
    .clk(clk), .rst(rst), .clkEn(ceA), .syncClr(clrA), .syncSet(setA), .syncInit(1'b0),
    .countUp(upA), .loadEn(ldNA), .loadVal(ldValA), .count(cntA), .threshHit(thA)
  );

  stepcnt_top #(
    .WIDTH(8), .MODE(CNT_UP), .STEP(8'd2), .RESTRICT(1'b1), .FINAL_VAL(8'd8),
    .HAS_CE(1'b1), .HAS_CLR(1'b0), .HAS_INIT(1'b1), .INIT_VAL(8'd4), .HAS_LOAD(1'b1),
    .LOAD_ACTIVE_HIGH(1'b1), .CE_GATES_SYNC(1'b1), .POWERUP_VAL(8'd0)
  ) dutLim_i (
    .clk(clk), .rst(rst), .clkEn(ceB), .syncClr(1'b0), .syncSet(1'b0), .syncInit(initB),
    .countUp(1'b1), .loadEn(ldB), .loadVal(ldValB), .count(cntB), .threshHit(thB)
  );

  stepcnt_top #(
    .WIDTH(4), .MODE(CNT_DOWN), .STEP(4'd3), .RESTRICT(1'b1), .FINAL_VAL(4'd10),
    .HAS_CE(1'b1), .HAS_CLR(1'b1), .POWERUP_VAL(4'd0)
  ) dutDown_i (
    .clk(clk), .rst(rst), .clkEn(ceC), .syncClr(clrC), .syncSet(1'b0), .syncInit(1'b0),
    .countUp(1'b0), .loadEn(1'b0), .loadVal(4'd0), .count(cntC), .threshHit(thC)
  );

  // {ce, clr, set, up, loadN, loadVal[7:0], expCount[7:0], expThresh}
  localparam int NV = 16;
  localparam logic [21:0] VEC_A [NV] = '{
    {1'b1,1'b0,1'b0,1'b1,1'b1, 8'h00, 8'h08, 1'b0},
    {1'b1,1'b0,1'b0,1'b0,1'b1, 8'h00, 8'h05, 1'b0},
    {1'b0,1'b0,1'b0,1'b1,1'b1, 8'h00, 8'h05, 1'b0},
    {1'b1,1'b0,1'b0,1'b1,1'b0, 8'h09, 8'h09, 1'b1},
    {1'b1,1'b0,1'b0,1'b1,1'b1, 8'h00, 8'h0C, 1'b0},
    {1'b0,1'b0,1'b0,1'b1,1'b0, 8'h40, 8'h0C, 1'b0},
    {1'b0,1'b1,1'b0,1'b1,1'b1, 8'h00, 8'h00, 1'b0},
    {1'b1,1'b0,1'b1,1'b1,1'b1, 8'h00, 8'hFF, 1'b0},
    {1'b1,1'b0,1'b0,1'b1,1'b1, 8'h00, 8'h02, 1'b0},
    {1'b1,1'b0,1'b0,1'b0,1'b1, 8'h00, 8'hFF, 1'b0},
    {1'b1,1'b1,1'b1,1'b1,1'b1, 8'h00, 8'h00, 1'b0},
    {1'b1,1'b0,1'b0,1'b1,1'b0, 8'h77, 8'h77, 1'b0},
    {1'b1,1'b1,1'b0,1'b1,1'b0, 8'h33, 8'h00, 1'b0},
    {1'b0,1'b0,1'b1,1'b1,1'b1, 8'h00, 8'hFF, 1'b0},
    {1'b1,1'b0,1'b0,1'b1,1'b0, 8'h06, 8'h06, 1'b0},
    {1'b1,1'b0,1'b0,1'b0,1'b1, 8'h00, 8'h03, 1'b0}
  };

  function automatic string tagA(input int idx);
    case (idx)
      0, 8:           return "R2";
      1, 9, 15:       return "R3";
      2:              return "R11";
      3, 5, 11, 12, 14: return "R10";
      6, 13:          return "R9";
      default:        return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    // R1: power-up values
    tick(); tick();
    chk("R1", cntA, 8'h05);
    chk("R1", cntB, 8'h00);
    chk("R1", {4'h0, cntC}, 8'h00);
    rst = 1'b0;

    // Vector walk on instance A
    for (int i = 0; i < NV; i++) begin
      {ceA, clrA, setA, upA, ldNA, ldValA} = VEC_A[i][21:9];
      tick();
      chk(tagA(i), cntA, VEC_A[i][8:1]);
      chk("R12", {7'd0, thA}, {7'd0, VEC_A[i][0]});
    end
    {ceA, clrA, setA, upA, ldNA, ldValA} = {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00};

    // R4: limited up counter wraps at 8
    ceB = 1'b1;
    tick(); chk("R4", cntB, 8'd2);
    tick(); chk("R4", cntB, 8'd4);
    tick(); chk("R4", cntB, 8'd6);
    tick(); chk("R4", cntB, 8'd8);
    tick(); chk("R4", cntB, 8'd0);
    // R9: enable gates initialise in this instance
    ceB = 1'b0; initB = 1'b1;
    tick(); chk("R9", cntB, 8'd0);
    // R8: initialise with enable
    ceB = 1'b1;
    tick(); chk("R8", cntB, 8'd4);
    initB = 1'b0;
    tick(); chk("R4", cntB, 8'd6);
    // R10: active-high load of an off-grid value
    ldB = 1'b1; ldValB = 8'd3;
    tick(); chk("R10", cntB, 8'd3);
    ldB = 1'b0;
    // R6: equality miss, no wrap past the limit
    tick(); chk("R6", cntB, 8'd5);
    tick(); chk("R6", cntB, 8'd7);
    tick(); chk("R6", cntB, 8'd9);
    tick(); chk("R6", cntB, 8'd11);
    // R10: initialise beats load
    ldB = 1'b1; ldValB = 8'h20; initB = 1'b1;
    tick(); chk("R10", cntB, 8'd4);
    // R10: load ignored with enable low
    initB = 1'b0; ceB = 1'b0;
    tick(); chk("R10", cntB, 8'd4);
    ldB = 1'b0;

    // R5: limited down counter
    ceC = 1'b1;
    tick(); chk("R5", {4'h0, cntC}, 8'd13);
    tick(); chk("R5", {4'h0, cntC}, 8'd10);
    tick(); chk("R5", {4'h0, cntC}, 8'd0);
    tick(); chk("R5", {4'h0, cntC}, 8'd13);
    // R7: clear overrides counting
    clrC = 1'b1;
    tick(); chk("R7", {4'h0, cntC}, 8'd0);
    clrC = 1'b0; ceC = 1'b0;
    tick(); chk("R11", {4'h0, cntC}, 8'd0);

    // R1: reset mid-run
    ceA = 1'b1; ceB = 1'b1; ceC = 1'b1;
    tick();
    rst = 1'b1;
    tick();
    chk("R1", cntA, 8'h05);
    chk("R1", cntB, 8'h00);
    chk("R1", {4'h0, cntC}, 8'h00);
    chk("R12", {7'd0, thA}, 8'd0);
    ceA = 1'b0; ceB = 1'b0; ceC = 1'b0;
    tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule